// File: doc/BRIEF.md
# RTC Power-Fail Status and Control Register

This block is an 8-bit control and status register for a real-time-clock core. It holds the supply-monitor threshold choice, a sticky low-supply flag, a sticky oscillator-halt flag, two scratch bits and three general event flags. Software reads and writes the whole byte through a plain synchronous write strobe and a read bus that always shows the current contents. Hardware sets the flags through a supply comparator result, an oscillator-halt detector and three event set lines.

The flags are sticky. Once set, a flag stays set until software writes 0 to that bit position. Writing 1 to a flag does nothing. If a set source is active in the same cycle as a clearing write, the set wins.

An oscillator halt is the strongest event. It wipes every other bit and issues a single-cycle global-clear pulse, which companion registers use to zero themselves. While the halt flag is set, the interrupt outputs are blocked and the 32.768 kHz clock output is forced on. None of the pins are streams, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_pf_ctrl`

## Requirements
- R1: After reset the register reads 0x10, with only the halt flag at bit 4 set. After reset `mon_en_o` is 1, `thr_sel_o` is 0 and `glb_clr_o` is 0.
- R2: Bit 7 is a read/write threshold select, and `thr_sel_o` follows it. The value 0 selects the higher (2.1 V) threshold and the value 1 selects the lower (1.6 V) threshold.
- R3: Bit 6 is the low-supply flag. It sets at the edge where `low_supply_i` is 1 and then stays 1 whatever the comparator does. `mon_en_o` is 0 while bit 6 is 1.
- R4: Writing 0 to bit 6 clears the flag and sets `mon_en_o` back to 1. Writing 1 to bit 6 leaves the flag unchanged.
- R5: Bits 5 and 3 are scratch bits. Each reads back the value last written to it.
- R6: Bit 4 is the oscillator-halt flag. It sets when `osc_halt_i` is 1 and stays set after `osc_halt_i` returns to 0. Only a written 0 clears it; a written 1 is ignored.
- R7: At every edge where `osc_halt_i` is 1, all bits other than bit 4 become 0. Any write in that cycle is ignored.
- R8: `glb_clr_o` is 1 for exactly one cycle: the first cycle in which a newly set halt flag reads 1. The power-on value of the halt flag does not produce this pulse.
- R9: `irq_block_o` and `clk32_en_o` are 1 exactly while bit 4 reads 1.
- R10: Bits 2, 1 and 0 are sticky event flags, set by `evt_set_i[2]`, `evt_set_i[1]` and `evt_set_i[0]` respectively. Writing 0 to a bit clears that flag; writing 1 leaves it unchanged.
- R11: For every flag (bits 6, 4, 2, 1 and 0), when the set source is active in the same cycle as a write of 0 to that bit, the flag ends up 1.
- R12: A write takes effect at the clock edge where `wr_en_i` is sampled high, and `rd_data_o` shows the new value from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Write strobe for the whole byte |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current register contents |
| low_supply_i | input | 1 | Comparator result, 1 when supply is below threshold |
| osc_halt_i | input | 1 | Oscillator halt detected |
| evt_set_i | input | 3 | Set lines for event flags at bits 2..0 |
| mon_en_o | output | 1 | Supply monitor enable |
| thr_sel_o | output | 1 | Threshold select to the comparator |
| glb_clr_o | output | 1 | One-cycle clear pulse to companion registers |
| irq_block_o | output | 1 | Forces interrupt outputs inactive |
| clk32_en_o | output | 1 | Forces the 32.768 kHz clock output on |

## Verification
The bench targets the cases where a set source and a clearing write land on the same edge. A design that gave the write priority there would drop a live event. It writes 1 to every flag, which catches a design that stores plain data in those bits. It also clears each flag while its source is still active, which exposes a missing sticky path. The halt case drives a full register, then writes during the halt. A design with an incomplete wipe, or one that let the write through, would leave stray bits. A design whose clear pulse was level-driven would hold `glb_clr_o` for the whole halt.

// File: rtl/rtc_pf_pkg.sv
`timescale 1ns/1ps
package rtc_pf_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_EVT   = 3;
  localparam int NUM_SCR   = 2;
  localparam int BIT_THR   = 7;
  localparam int BIT_LVD   = 6;
  localparam int BIT_HALT  = 4;
  localparam int EVT_LSB   = 0;
  typedef logic [REG_W-1:0] ctrl_word_t;
  localparam ctrl_word_t HALT_MASK = ctrl_word_t'(1) << BIT_HALT;

  function automatic int scr_pos(input int idx);
    return (idx == 0) ? 5 : 3;
  endfunction
endpackage

// File: rtl/rtc_pf_sticky.sv
`timescale 1ns/1ps
module rtc_pf_sticky #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wipe_i,
  input  logic clr_req_i,
  output logic q_o
);
  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= RST_VAL;
    else if (wipe_i) q_r <= 1'b0;
    else if (set_i)  q_r <= 1'b1;
    else if (clr_req_i) q_r <= 1'b0;
  end

  assign q_o = q_r;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !wipe_i |=> q_o) else $error("set lost"); // R11
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    q_o && !clr_req_i && !wipe_i |=> q_o) else $error("flag dropped"); // R10
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !q_o && !set_i |=> !q_o) else $error("flag set without source"); // R4
endmodule

// File: rtl/rtc_pf_store.sv
`timescale 1ns/1ps
module rtc_pf_store (
  input  logic clk,
  input  logic rst_n,
  input  logic wipe_i,
  input  logic wr_i,
  input  logic d_i,
  output logic q_o
);
  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= 1'b0;
    else if (wipe_i) q_r <= 1'b0;
    else if (wr_i)   q_r <= d_i;
  end

  assign q_o = q_r;

  AST_STORE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && !wipe_i |=> q_o == $past(d_i)) else $error("store mismatch"); // R5
endmodule

// File: rtl/rtc_pf_halt.sv
`timescale 1ns/1ps
module rtc_pf_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_halt_i,
  input  logic clr_req_i,
  output logic halt_o,
  output logic glb_clr_o,
  output logic irq_block_o,
  output logic clk32_en_o
);
  logic halt_q;
  logic pulse_q;

  rtc_pf_sticky #(.RST_VAL(1'b1)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (osc_halt_i),
    .wipe_i    (1'b0),
    .clr_req_i (clr_req_i),
    .q_o       (halt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= osc_halt_i & ~halt_q;
  end

  assign halt_o      = halt_q;
  assign glb_clr_o   = pulse_q;
  assign irq_block_o = halt_q;
  assign clk32_en_o  = halt_q;

  AST_GCLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    glb_clr_o |=> !glb_clr_o) else $error("clear pulse too long"); // R8
  AST_GCLR_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    glb_clr_o |-> halt_o) else $error("pulse without flag"); // R8
  AST_HALT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o && !clr_req_i |=> halt_o) else $error("halt dropped"); // R6
endmodule

// File: rtl/rtc_pf_ctrl.sv
`timescale 1ns/1ps
module rtc_pf_ctrl
  import rtc_pf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   rd_data_o,
  input  logic               low_supply_i,
  input  logic               osc_halt_i,
  input  logic [NUM_EVT-1:0] evt_set_i,
  output logic               mon_en_o,
  output logic               thr_sel_o,
  output logic               glb_clr_o,
  output logic               irq_block_o,
  output logic               clk32_en_o
);
  ctrl_word_t word;
  logic       wipe;
  logic       thr_q;
  logic       lvd_q;
  logic       halt_q;
  logic [NUM_SCR-1:0] scr_q;
  logic [NUM_EVT-1:0] evt_q;

  assign wipe = osc_halt_i;

  rtc_pf_store u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .wipe_i(wipe),
    .wr_i  (wr_en_i),
    .d_i   (wr_data_i[BIT_THR]),
    .q_o   (thr_q)
  );

  rtc_pf_sticky #(.RST_VAL(1'b0)) u_lvd (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (low_supply_i),
    .wipe_i    (wipe),
    .clr_req_i (wr_en_i & ~wr_data_i[BIT_LVD]),
    .q_o       (lvd_q)
  );

  rtc_pf_halt u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_halt_i  (osc_halt_i),
    .clr_req_i   (wr_en_i & ~wr_data_i[BIT_HALT]),
    .halt_o      (halt_q),
    .glb_clr_o   (glb_clr_o),
    .irq_block_o (irq_block_o),
    .clk32_en_o  (clk32_en_o)
  );

  for (genvar s = 0; s < NUM_SCR; s++) begin : g_scr
    localparam int POS = scr_pos(s);
    rtc_pf_store u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .wipe_i(wipe),
      .wr_i  (wr_en_i),
      .d_i   (wr_data_i[POS]),
      .q_o   (scr_q[s])
    );
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    localparam int POS = EVT_LSB + e;
    rtc_pf_sticky #(.RST_VAL(1'b0)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (evt_set_i[e]),
      .wipe_i    (wipe),
      .clr_req_i (wr_en_i & ~wr_data_i[POS]),
      .q_o       (evt_q[e])
    );
  end

  always_comb begin
    word = '0;
    word[BIT_THR]  = thr_q;
    word[BIT_LVD]  = lvd_q;
    word[BIT_HALT] = halt_q;
    for (int s = 0; s < NUM_SCR; s++) word[scr_pos(s)] = scr_q[s];
    for (int e = 0; e < NUM_EVT; e++) word[EVT_LSB + e] = evt_q[e];
  end

  assign rd_data_o = word;
  assign mon_en_o  = ~lvd_q;
  assign thr_sel_o = thr_q;

  AST_HALT_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    osc_halt_i |=> rd_data_o == HALT_MASK) else $error("halt wipe incomplete"); // R7
  AST_MON_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en_o && !osc_halt_i && !(wr_en_i && !wr_data_i[BIT_LVD]) |=> !mon_en_o)
    else $error("monitor re-enabled without clear"); // R3
  AST_THR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !osc_halt_i |=> thr_sel_o == $past(wr_data_i[BIT_THR]))
    else $error("threshold write lost"); // R2
endmodule

// File: tb/sim_rtc_pf_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_pf_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       low_supply_i = 1'b0;
  logic       osc_halt_i = 1'b0;
  logic [2:0] evt_set_i = 3'b000;
  logic       mon_en_o, thr_sel_o, glb_clr_o, irq_block_o, clk32_en_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_pf_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .low_supply_i(low_supply_i), .osc_halt_i(osc_halt_i),
    .evt_set_i(evt_set_i), .mon_en_o(mon_en_o), .thr_sel_o(thr_sel_o),
    .glb_clr_o(glb_clr_o), .irq_block_o(irq_block_o), .clk32_en_o(clk32_en_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reg", rd_data_o, 8'h10);
    chk("R1 mon_en", {7'd0, mon_en_o}, 8'd1);
    chk("R1 thr", {7'd0, thr_sel_o}, 8'd0);
    chk("R1 glb", {7'd0, glb_clr_o}, 8'd0);
    chk("R9 irq_block at reset", {7'd0, irq_block_o}, 8'd1);
    chk("R9 clk32 at reset", {7'd0, clk32_en_o}, 8'd1);
    tick();
    chk("R8 no pulse after reset", {7'd0, glb_clr_o}, 8'd0);
    wr(8'h00);
    chk("R6 halt cleared by 0", rd_data_o, 8'h00);
    chk("R9 irq_block off", {7'd0, irq_block_o}, 8'd0);
    chk("R9 clk32 off", {7'd0, clk32_en_o}, 8'd0);
  endtask

  task automatic t_rw;
    wr(8'hA8);
    chk("R12 R5 scratch and thr", rd_data_o, 8'hA8);
    chk("R2 thr_sel low threshold", {7'd0, thr_sel_o}, 8'd1);
    wr(8'h20);
    chk("R5 scratch mix", rd_data_o, 8'h20);
    chk("R2 thr_sel high threshold", {7'd0, thr_sel_o}, 8'd0);
    wr(8'h28);
    chk("R5 both scratch", rd_data_o, 8'h28);
  endtask

  task automatic t_lvd;
    low_supply_i = 1'b1;
    tick();
    low_supply_i = 1'b0;
    chk("R3 lvd set", rd_data_o, 8'h68);
    chk("R3 mon off", {7'd0, mon_en_o}, 8'd0);
    tick();
    chk("R3 lvd sticky", rd_data_o, 8'h68);
    wr(8'h68);
    chk("R4 write 1 ignored", rd_data_o, 8'h68);
    low_supply_i = 1'b1;
    wr(8'h28);
    low_supply_i = 1'b0;
    chk("R11 lvd set beats clear", rd_data_o, 8'h68);
    wr(8'h28);
    chk("R4 lvd cleared", rd_data_o, 8'h28);
    chk("R4 mon back on", {7'd0, mon_en_o}, 8'd1);
  endtask

  task automatic t_evt;
    for (int k = 0; k < 3; k++) begin
      logic [7:0] m;
      m = 8'(1 << k);
      evt_set_i[k] = 1'b1;
      tick();
      evt_set_i[k] = 1'b0;
      chk("R10 evt set", rd_data_o, 8'h28 | m);
      tick();
      chk("R10 evt sticky", rd_data_o, 8'h28 | m);
      wr(8'h28 | m);
      chk("R10 evt write 1 ignored", rd_data_o, 8'h28 | m);
      evt_set_i[k] = 1'b1;
      wr(8'h28);
      evt_set_i[k] = 1'b0;
      chk("R11 evt set beats clear", rd_data_o, 8'h28 | m);
      wr(8'h28);
      chk("R10 evt cleared", rd_data_o, 8'h28);
    end
  endtask

  task automatic t_halt;
    wr(8'hA8);
    evt_set_i = 3'b111;
    low_supply_i = 1'b1;
    tick();
    evt_set_i = 3'b000;
    low_supply_i = 1'b0;
    chk("R3 R10 preload", rd_data_o, 8'hEF);
    osc_halt_i = 1'b1;
    tick();
    chk("R7 wipe", rd_data_o, 8'h10);
    chk("R8 pulse", {7'd0, glb_clr_o}, 8'd1);
    chk("R9 irq_block", {7'd0, irq_block_o}, 8'd1);
    chk("R9 clk32", {7'd0, clk32_en_o}, 8'd1);
    chk("R4 mon back after wipe", {7'd0, mon_en_o}, 8'd1);
    wr(8'hEF);
    chk("R7 write ignored in halt", rd_data_o, 8'h10);
    chk("R8 pulse ends", {7'd0, glb_clr_o}, 8'd0);
    osc_halt_i = 1'b0;
    tick();
    chk("R6 halt sticky", rd_data_o, 8'h10);
    wr(8'h10);
    chk("R6 write 1 ignored", rd_data_o, 8'h10);
    wr(8'hA8);
    chk("R6 halt cleared", rd_data_o, 8'hA8);
    chk("R9 irq_block released", {7'd0, irq_block_o}, 8'd0);
    osc_halt_i = 1'b1;
    wr(8'h00);
    osc_halt_i = 1'b0;
    chk("R11 halt set beats clear", rd_data_o, 8'h10);
    chk("R8 second pulse", {7'd0, glb_clr_o}, 8'd1);
    tick();
    chk("R8 second pulse ends", {7'd0, glb_clr_o}, 8'd0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_rw();
    t_lvd();
    t_evt();
    t_halt();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule